// File: doc/BRIEF.md
# Repeater Event Interrupt Status Register

This block collects six kinds of single-cycle event pulses from a multi-port repeater into one 32-bit status word. The six events are speed change, source address change, false carrier count, partition, isolate and jabber. Once an event pulse is seen, its bit stays at 1 until software clears it. A combined interrupt line is high while any bit is set.

The `w1c_mode_i` input selects how bits are cleared, and it can change at any time. When it is high, software clears individual bits by writing 1 to them. When it is low, a read access clears the whole word. In that case the data shown during the read strobe is the value held before the clear takes effect. The bits are cleared at the clock edge that ends the access.

Each status bit is a two-state cell. Its states are `CELL_IDLE` (bit reads 0) and `CELL_LATCHED` (bit reads 1). The cell has three transitions:
- CAPTURE: from `CELL_IDLE` to `CELL_LATCHED` on an event pulse.
- RELEASE: from `CELL_LATCHED` to `CELL_IDLE` on a clear request that does not coincide with an event.
- HOLD: the cell stays where it is for every other input combination.

An access decoder turns the mode select, read strobe, write strobe and write data into one clear request per bit.

Top module: `irq_status_reg`

## Requirements
- R1: A one-cycle pulse on `event_i[k]` makes bit k of `rd_data_o` read 1 from the next cycle onward, and the bit stays 1 until it is cleared. The bit mapping is:
  - bit 0: speed change
  - bit 1: source address change
  - bit 2: false carrier count
  - bit 3: partition
  - bit 4: isolate
  - bit 5: jabber
- R2: Bits 31:6 of `rd_data_o` always read 0, including after writes of all ones.
- R3: While `rst_n` is low, and in the first cycle after it rises, every status bit and `irq_o` are 0.
- R4: With `w1c_mode_i` = 1, a write (`wr_en_i` = 1) clears each status bit whose `wr_data_i` bit is 1, as of the next cycle.
- R5: With `w1c_mode_i` = 1, a write with a 0 in a bit position leaves that bit unchanged, and a read strobe clears nothing.
- R6: With `w1c_mode_i` = 0, a cycle with `rd_en_i` = 1 clears all status bits as of the next cycle. During that cycle, `rd_data_o` still shows the value held before the clear.
- R7: With `w1c_mode_i` = 0, writes have no effect on the status bits.
- R8: If an event pulse arrives in the same cycle as a clear of its bit, the bit reads 1 afterwards.
- R9: `irq_o` is 1 exactly when any of bits 5:0 of `rd_data_o` is 1.
- R10: The clear method is chosen by the value of `w1c_mode_i` in the access cycle, so switching the mode between accesses takes effect on the next access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| event_i | input | 6 | Event pulses; bit k sets status bit k |
| w1c_mode_i | input | 1 | 1 = write-one-to-clear, 0 = clear-on-read |
| rd_en_i | input | 1 | Read access strobe |
| wr_en_i | input | 1 | Write access strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Status word, reserved bits zero |
| irq_o | output | 1 | OR of all status bits |

## Verification
An event pulse and a clear of the same bit can land in the same cycle, in either clear mode. The bench provokes this in write-one-to-clear mode by pulsing the event together with a write of 1 to that bit. In clear-on-read mode it does so by pulsing the event together with a read strobe. In both cases the bit must read 1 in the following cycle while every other cleared bit reads 0. The clear-on-read case is also checked in the strobe cycle itself, where the word must still show its pre-clear value.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
    localparam int N_EVT  = 6;
    localparam int DATA_W = 32;

    localparam int EVT_SPEED  = 0;
    localparam int EVT_SRCADR = 1;
    localparam int EVT_FCAR   = 2;
    localparam int EVT_PART   = 3;
    localparam int EVT_ISOL   = 4;
    localparam int EVT_JAB    = 5;

    typedef enum logic {
        CELL_IDLE    = 1'b0,
        CELL_LATCHED = 1'b1
    } cell_state_t;
endpackage

// File: rtl/irq_clr_decode.sv
module irq_clr_decode #(
    parameter int N = 6
) (
    input  logic         w1c_mode_i,
    input  logic         rd_en_i,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_bits_i,
    output logic [N-1:0] clr_o
);
    always_comb begin
        if (w1c_mode_i) begin
            clr_o = wr_en_i ? wr_bits_i : '0;
        end else begin
            clr_o = rd_en_i ? '1 : '0;
        end
    end
endmodule

// File: rtl/irq_evt_cell.sv
module irq_evt_cell
    import irq_status_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic evt_i,
    input  logic clr_i,
    output logic bit_o
);
    cell_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CELL_IDLE;
        else        state_q <= state_d;
    end

    // CAPTURE / RELEASE / HOLD; an event always wins over a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CELL_IDLE:    if (evt_i)           state_d = CELL_LATCHED;
            CELL_LATCHED: if (clr_i && !evt_i) state_d = CELL_IDLE;
            default:                           state_d = CELL_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            CELL_LATCHED: bit_o = 1'b1;
            default:      bit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg
    import irq_status_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NE = N_EVT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NE-1:0] event_i,
    input  logic          w1c_mode_i,
    input  logic          rd_en_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    output logic [DW-1:0] rd_data_o,
    output logic          irq_o
);
    localparam int RSV_W = DW - NE;

    logic [NE-1:0] clr_vec;
    logic [NE-1:0] status;
    logic          unused_wr_hi;

    assign unused_wr_hi = ^wr_data_i[DW-1:NE];

    irq_clr_decode #(.N(NE)) dec_i (
        .w1c_mode_i (w1c_mode_i),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .wr_bits_i  (wr_data_i[NE-1:0]),
        .clr_o      (clr_vec)
    );

    for (genvar k = 0; k < NE; k++) begin : g_cell
        irq_evt_cell cell_i (
            .clk   (clk),
            .rst_n (rst_n),
            .evt_i (event_i[k]),
            .clr_i (clr_vec[k]),
            .bit_o (status[k])
        );
    end

    // read data shows the held value; a clear lands at the closing edge
    assign rd_data_o = {{RSV_W{1'b0}}, status};
    assign irq_o     = |status;
endmodule

module irq_status_chk #(
    parameter int DW = 32,
    parameter int NE = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NE-1:0] event_i,
    input logic          w1c_mode_i,
    input logic          rd_en_i,
    input logic          wr_en_i,
    input logic [DW-1:0] wr_data_i,
    input logic [DW-1:0] rd_data_o,
    input logic          irq_o
);
    p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data_o[DW-1:NE] == '0);

    p_evt_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (|event_i) |=> ((rd_data_o[NE-1:0] & $past(event_i)) == $past(event_i)));

    p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (|rd_data_o[NE-1:0]));

    p_w1c_zero_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_mode_i && wr_en_i) |=>
        ((($past(rd_data_o[NE-1:0]) & ~$past(wr_data_i[NE-1:0])) & ~rd_data_o[NE-1:0]) == '0));

    p_w1c_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_mode_i && wr_en_i && event_i == '0) |=>
        ((rd_data_o[NE-1:0] & $past(wr_data_i[NE-1:0])) == '0));

    p_cor_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_mode_i && rd_en_i && event_i == '0) |=> rd_data_o[NE-1:0] == '0);

    p_cor_wr_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!w1c_mode_i && !rd_en_i && event_i == '0) |=> $stable(rd_data_o));
endmodule

bind irq_status_reg irq_status_chk #(.DW(DW), .NE(NE)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .event_i    (event_i),
    .w1c_mode_i (w1c_mode_i),
    .rd_en_i    (rd_en_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .irq_o      (irq_o)
);

// File: tb/irq_status_reg_tb.sv
module irq_status_reg_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  event_i;
    logic        w1c_mode_i;
    logic        rd_en_i;
    logic        wr_en_i;
    logic [31:0] wr_data_i;
    logic [31:0] rd_data_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    irq_status_reg dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .event_i    (event_i),
        .w1c_mode_i (w1c_mode_i),
        .rd_en_i    (rd_en_i),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .rd_data_o  (rd_data_o),
        .irq_o      (irq_o)
    );

    // vector: {mode, evt[5:0], rd, wr, wd[5:0], exp[5:0]}
    localparam int NV = 16;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 6'b000001, 1'b0, 1'b0, 6'b000000, 6'b000001}, // R1 speed
        {1'b1, 6'b100000, 1'b0, 1'b0, 6'b000000, 6'b100001}, // R1 jabber
        {1'b1, 6'b000000, 1'b1, 1'b0, 6'b000000, 6'b100001}, // R5 read keeps
        {1'b1, 6'b000000, 1'b0, 1'b1, 6'b000000, 6'b100001}, // R5 write 0 keeps
        {1'b1, 6'b000000, 1'b0, 1'b1, 6'b000001, 6'b100000}, // R4 clear bit0
        {1'b1, 6'b011110, 1'b0, 1'b0, 6'b000000, 6'b111110}, // R1 middle bits
        {1'b1, 6'b000010, 1'b0, 1'b1, 6'b000010, 6'b111110}, // R8 evt vs w1c
        {1'b1, 6'b000000, 1'b0, 1'b1, 6'b111111, 6'b000000}, // R4 clear all
        {1'b0, 6'b010101, 1'b0, 1'b0, 6'b000000, 6'b010101}, // R1 in cor mode
        {1'b0, 6'b000000, 1'b0, 1'b1, 6'b111111, 6'b010101}, // R7 write ignored
        {1'b0, 6'b000000, 1'b1, 1'b0, 6'b000000, 6'b000000}, // R6 read clears
        {1'b0, 6'b001000, 1'b1, 1'b0, 6'b000000, 6'b001000}, // R8 evt vs read
        {1'b0, 6'b000000, 1'b1, 1'b0, 6'b000000, 6'b000000}, // R6
        {1'b0, 6'b111111, 1'b0, 1'b0, 6'b000000, 6'b111111}, // R1 all
        {1'b1, 6'b000000, 1'b1, 1'b0, 6'b000000, 6'b111111}, // R10 now w1c
        {1'b0, 6'b000000, 1'b1, 1'b0, 6'b000000, 6'b000000}  // R10 back to cor
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        event_i = '0; rd_en_i = 1'b0; wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    initial begin
        rst_n = 1'b0; w1c_mode_i = 1'b1;
        idle_inputs();
        repeat (3) @(negedge clk);
        check("R3 reset data", rd_data_o, 32'h0);
        check("R3 reset irq", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 after release", rd_data_o, 32'h0);

        for (int i = 0; i < NV; i++) begin
            logic [20:0] v;
            v = VEC[i];
            w1c_mode_i = v[20];
            event_i    = v[19:14];
            rd_en_i    = v[13];
            wr_en_i    = v[12];
            wr_data_i  = {26'h3ffffff, v[11:6]};
            @(negedge clk);
            idle_inputs();
            check($sformatf("R1/R2/R4-R8/R10 vec %0d data", i), rd_data_o, {26'h0, v[5:0]});
            check($sformatf("R9 vec %0d irq", i), {31'h0, irq_o}, {31'h0, |v[5:0]});
        end

        // R6: read data during the strobe still shows the pre-clear value
        w1c_mode_i = 1'b0;
        event_i = 6'b000110;
        @(negedge clk);
        idle_inputs();
        rd_en_i = 1'b1;
        #1;
        check("R6 pre-clear view", rd_data_o, 32'h6);
        @(negedge clk);
        idle_inputs();
        check("R6 cleared after read", rd_data_o, 32'h0);

        // R2: all-ones write in w1c mode leaves reserved bits at zero
        w1c_mode_i = 1'b1;
        event_i = 6'b111111;
        @(negedge clk);
        idle_inputs();
        wr_en_i = 1'b1; wr_data_i = 32'hFFFF_FFC0;
        @(negedge clk);
        idle_inputs();
        check("R2 reserved zero", rd_data_o, 32'h0000_003F);

        // R3: reset drops latched bits
        rst_n = 1'b0;
        @(negedge clk);
        check("R3 reset clears", rd_data_o, 32'h0);
        check("R3 reset irq low", {31'h0, irq_o}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule